// File: doc/BRIEF.md
# Five-Function Integer ALU with Operation Decoder

This block is the arithmetic unit of a small multicycle processor datapath, together with the decoder that picks its operation. The main controller supplies a 2-bit operation class. When the class calls for it, the decoder also reads the 6-bit function field of a register-to-register instruction. The decoder produces a three-bit control word made of one operand-negate bit and a two-bit result select. The arithmetic unit applies this control word to two operands of parameterised width, 8 bits by default.

The unit computes bitwise AND, bitwise OR, addition, subtraction and a signed less-than comparison. Subtraction has no adder of its own. It goes through the one shared adder, which receives the inverted second operand and a carry-in of 1. The less-than value is taken from that same subtraction, corrected for signed overflow, and appears as a single bit zero-extended to full width. A zero flag tells the controller whether every result bit is clear, which is how branch-on-equal compares two registers. The block is purely combinational: a change at the inputs reaches all outputs within the same cycle.

Top module: `alu5_top`

## Requirements
- R1: With control word 000 (negate 0, select 00) the result is the bitwise AND of A and B.
- R2: With control word 001 (negate 0, select 01) the result is the bitwise OR of A and B.
- R3: With control word 010 (negate 0, select 10) the result is A + B modulo 2^WIDTH.
- R4: With control word 110 (negate 1, select 10) the result is A - B modulo 2^WIDTH, formed by the adder from A, the inverted B and a carry-in of 1.
- R5: With control word 111 the result is 1 when A is less than B as signed two's-complement numbers and 0 otherwise, and all bits above bit 0 are 0.
- R6: The zero flag is 1 exactly when every result bit is 0.
- R7: Operation class 00 yields control word 010 (add) and class 01 yields control word 110 (subtract), whatever the function field holds.
- R8: Operation class 10 or 11 decodes the function field: 0x20 gives add (010), 0x22 subtract (110), 0x24 AND (000), 0x25 OR (001), 0x2A less-than (111).
- R9: Under operation class 10 or 11, a function code that is not listed in R8 decodes to add (010).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op_i | input | 2 | Operation class from the main controller |
| funct_i | input | 6 | Function field of a register-to-register instruction |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| ctl_o | output | 3 | Decoded control word: bit 2 negate, bits 1:0 result select |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The less-than function and the zero flag both depend on the shared subtraction in the same evaluation, so they can interact. The bench provokes this with equal operands under a subtract code, which must raise the zero flag. It also uses operand pairs whose difference overflows, such as 0x7F against 0x80, where the raw sign bit of the difference gives the wrong answer and the less-than output must follow the signed order. Each such case is judged against a model of the requirements, covering the result, the flag and the control word.

// File: rtl/alu5_pkg.sv
package alu5_pkg;
   typedef enum logic [1:0] {
      SEL_AND   = 2'b00,
      SEL_OR    = 2'b01,
      SEL_ARITH = 2'b10,
      SEL_SLT   = 2'b11
   } res_sel_e;

   typedef struct packed {
      logic     neg;
      res_sel_e sel;
   } alu_ctl_t;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/alu5_decode.sv
module alu5_decode
   import alu5_pkg::*;
#(
   parameter int FUNCT_W = 6
) (
   input  logic [1:0]         alu_op_i,
   input  logic [FUNCT_W-1:0] funct_i,
   output alu_ctl_t           ctl_o
);
   if (FUNCT_W != 6) begin : g_bad_funct
      $error("alu5_decode: FUNCT_W must be 6");
   end

   alu_ctl_t fn_ctl;

   always_comb begin
      unique case (funct_i)
         FN_SUB:  fn_ctl = '{neg: 1'b1, sel: SEL_ARITH};
         FN_AND:  fn_ctl = '{neg: 1'b0, sel: SEL_AND};
         FN_OR:   fn_ctl = '{neg: 1'b0, sel: SEL_OR};
         FN_SLT:  fn_ctl = '{neg: 1'b1, sel: SEL_SLT};
         default: fn_ctl = '{neg: 1'b0, sel: SEL_ARITH};
      endcase
   end

   always_comb begin
      if (alu_op_i[1])
         ctl_o = fn_ctl;
      else
         ctl_o = '{neg: alu_op_i[0], sel: SEL_ARITH};
   end

   always_comb begin
      // R4
      neg_only_arith_chk: assert (!ctl_o.neg || ctl_o.sel == SEL_ARITH || ctl_o.sel == SEL_SLT)
         else $error("negate asserted with a logic select");
      // R7
      class_sub_chk: assert (alu_op_i != 2'b01 || ctl_o.neg)
         else $error("subtract class without negate");
   end
endmodule

// File: rtl/alu5_adder.sv
module alu5_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("alu5_adder: WIDTH must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum_o[i]    = a_i[i] ^ b_i[i] ^ carry[i];
         assign carry[i+1]  = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
      end
      assign cout_o = carry[WIDTH];
   end else begin : g_behav
      logic [WIDTH:0] wide;
      assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
      assign sum_o  = wide[WIDTH-1:0];
      assign cout_o = wide[WIDTH];
   end
endmodule

// File: rtl/alu5_core.sv
module alu5_core
   import alu5_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  alu_ctl_t         ctl_i,
   output logic [WIDTH-1:0] result_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum;
   logic             cout_unused;
   logic             ovf;
   logic             less;

   assign b_eff = ctl_i.neg ? ~b_i : b_i;

   alu5_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .a_i   (a_i),
      .b_i   (b_eff),
      .cin_i (ctl_i.neg),
      .sum_o (sum),
      .cout_o(cout_unused)
   );

   assign ovf  = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
   assign less = sum[MSB] ^ ovf;

   always_comb begin
      unique case (ctl_i.sel)
         SEL_AND:   result_o = a_i & b_i;
         SEL_OR:    result_o = a_i | b_i;
         SEL_ARITH: result_o = sum;
         default:   result_o = {{(WIDTH-1){1'b0}}, less};
      endcase
   end

   always_comb begin
      // R1
      and_subset_chk: assert (ctl_i.sel != SEL_AND || (result_o & ~a_i) == '0)
         else $error("AND result has bits outside A");
      // R2
      or_superset_chk: assert (ctl_i.sel != SEL_OR || (a_i & ~result_o) == '0)
         else $error("OR result misses bits of A");
      // R5
      slt_extend_chk: assert (ctl_i.sel != SEL_SLT || result_o[MSB:1] == '0)
         else $error("less-than result not zero-extended");
   end
endmodule

// File: rtl/alu5_top.sv
module alu5_top
   import alu5_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int FUNCT_W = 6,
   parameter bit RIPPLE  = 1'b1
) (
   input  logic [1:0]         alu_op_i,
   input  logic [FUNCT_W-1:0] funct_i,
   input  logic [WIDTH-1:0]   a_i,
   input  logic [WIDTH-1:0]   b_i,
   output logic [2:0]         ctl_o,
   output logic [WIDTH-1:0]   result_o,
   output logic               zero_o
);
   alu_ctl_t ctl;

   alu5_decode #(.FUNCT_W(FUNCT_W)) u_dec (
      .alu_op_i(alu_op_i),
      .funct_i (funct_i),
      .ctl_o   (ctl)
   );

   alu5_core #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_core (
      .a_i     (a_i),
      .b_i     (b_i),
      .ctl_i   (ctl),
      .result_o(result_o)
   );

   assign ctl_o  = ctl;
   assign zero_o = ~|result_o;

   always_comb begin
      // R6
      equal_sub_zero_chk: assert (!(alu_op_i == 2'b01 && a_i == b_i) || zero_o)
         else $error("equal operands under subtract did not raise zero");
   end
endmodule

// File: tb/alu5_top_tb.sv
module alu5_top_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] alu_op;
   logic [5:0] funct;
   logic [7:0] a, b;
   logic [2:0] ctl;
   logic [7:0] result;
   logic       zero;
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   alu5_top u_dut (
      .alu_op_i(alu_op), .funct_i(funct), .a_i(a), .b_i(b),
      .ctl_o(ctl), .result_o(result), .zero_o(zero)
   );

   // vector = {class, funct, a, b}
   localparam logic [23:0] VEC [14] = '{
      {2'b10, 6'h24, 8'hF0, 8'h3C},   // R1 AND
      {2'b10, 6'h25, 8'hF0, 8'h0F},   // R2 OR
      {2'b10, 6'h20, 8'hFF, 8'h01},   // R3 add wraps to zero
      {2'b10, 6'h20, 8'h12, 8'h34},   // R3
      {2'b10, 6'h22, 8'h05, 8'h07},   // R4 borrow
      {2'b10, 6'h22, 8'h55, 8'h55},   // R4 R6 equal
      {2'b10, 6'h2A, 8'h7F, 8'h80},   // R5 overflow case
      {2'b10, 6'h2A, 8'h80, 8'h7F},   // R5 overflow case
      {2'b10, 6'h2A, 8'hFE, 8'h01},   // R5 negative vs positive
      {2'b00, 6'h24, 8'h10, 8'h20},   // R7 class 00 ignores funct
      {2'b01, 6'h25, 8'h20, 8'h20},   // R7 class 01 ignores funct
      {2'b11, 6'h25, 8'h01, 8'h02},   // R8 class 11 decodes
      {2'b10, 6'h3F, 8'h40, 8'h41},   // R9 unknown code
      {2'b11, 6'h00, 8'hC0, 8'h40}    // R9 unknown code
   };

   function automatic logic [2:0] exp_ctl(input logic [1:0] op, input logic [5:0] fn);
      if (op == 2'b00) return 3'b010;
      if (op == 2'b01) return 3'b110;
      case (fn)
         6'h20: return 3'b010;
         6'h22: return 3'b110;
         6'h24: return 3'b000;
         6'h25: return 3'b001;
         6'h2A: return 3'b111;
         default: return 3'b010;
      endcase
   endfunction

   function automatic logic [7:0] exp_res(input logic [2:0] c, input logic [7:0] x, input logic [7:0] y);
      case (c)
         3'b000: return x & y;
         3'b001: return x | y;
         3'b010: return x + y;
         3'b110: return x - y;
         default: return ($signed(x) < $signed(y)) ? 8'd1 : 8'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply_and_check(input string tag, input logic [1:0] op, input logic [5:0] fn,
                                  input logic [7:0] x, input logic [7:0] y);
      logic [2:0] ec;
      logic [7:0] er;
      @(negedge clk);
      alu_op = op; funct = fn; a = x; b = y;
      #1;
      ec = exp_ctl(op, fn);
      er = exp_res(ec, x, y);
      check({tag, " ctl"}, {29'd0, ctl}, {29'd0, ec});
      check({tag, " result"}, {24'd0, result}, {24'd0, er});
      check({"R6 ", tag, " zero"}, {31'd0, zero}, {31'd0, (er == 8'd0)});
   endtask

   initial begin
      alu_op = 2'b00; funct = 6'h00; a = 8'h00; b = 8'h00;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // reset state: add class with zero operands
      check("R7 reset ctl", {29'd0, ctl}, 32'd2);
      check("R3 reset result", {24'd0, result}, 32'd0);
      check("R6 reset zero", {31'd0, zero}, 32'd1);

      for (int i = 0; i < 14; i++)
         apply_and_check("R8 table", VEC[i][23:22], VEC[i][21:16], VEC[i][15:8], VEC[i][7:0]);

      // R5 signed order across boundary values, each against its own model
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 6; j++) begin
            logic [7:0] vals [6];
            vals = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF};
            apply_and_check("R5 slt sweep", 2'b10, 6'h2A, vals[i], vals[j]);
            apply_and_check("R4 sub sweep", 2'b10, 6'h22, vals[i], vals[j]);
         end
      end

      // R1 R2 R3 stepped patterns
      for (int k = 0; k < 16; k++) begin
         apply_and_check("R1 and walk", 2'b10, 6'h24, 8'(k * 17), 8'(8'hA5 ^ k));
         apply_and_check("R2 or walk", 2'b10, 6'h25, 8'(k * 13), 8'(1 << (k % 8)));
         apply_and_check("R3 add walk", 2'b00, 6'h2A, 8'(k * 29), 8'(256 - k * 29));
      end

      // R9 every unlisted code behaves as add
      for (int f = 0; f < 64; f++) begin
         if (f != 'h20 && f != 'h22 && f != 'h24 && f != 'h25 && f != 'h2A)
            apply_and_check("R9 unknown", 2'b10, 6'(f), 8'h33, 8'h44);
      end

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule